// File: doc/BRIEF.md
# Pin Interrupt Channel Controller

This block gathers up to 32 port pins into one interrupt channel. The pins arrive as several half ports, which are groups of eight pins. Each of the channel's four byte lanes takes one half port, and a per-lane select field in the assignment register chooses which one. A pin is never routed on its own. Every bit of the channel can be edge or level sensitive, and its polarity is programmable. A detected event is held in a per-bit latch. The channel raises a single request line while any latched bit is also unmasked.

Software programs the channel through a flat register port of 32-bit words. The mask, edge-mode and polarity registers each have one address that sets bits and another that clears them, so single bits can change without a read-modify-write. The latch contents and the raw pin state can always be read, whatever the mask holds. A separate identify view shows only the unmasked pending bits. Writes are single-cycle strobes and reads are combinational. This is a control port, so it has no valid/ready handshake and never stalls.

Top module: `pint_channel`

## Requirements
- R1: After reset the mask, edge-mode, polarity and latch registers read zero, the request output is low, and lane i selects half port i (assignment word 0xE4).
- R2: Address 0x8 holds the assignment word, with a 2-bit half-port select for lane i at bits [2i+1:2i]. Address 0x9 reads the raw channel pins, where byte lane i carries the selected half port.
- R3: A write to 0x0 sets the mask bits that are one in the data, and a write to 0x1 clears them. Both addresses read the mask.
- R4: Addresses 0x2 and 0x3 set and clear edge-mode bits (1 = edge, 0 = level). Addresses 0x4 and 0x5 set and clear polarity-invert bits. Each pair reads its register.
- R5: A bit in edge mode latches on a rising edge of the pin XOR invert, one clock after the edge. It stays latched until it is cleared.
- R6: A bit in level mode shows the pin XOR invert in its latch one clock later, and writes that clear it have no lasting effect.
- R7: Address 0x6 reads the latch whatever the mask holds. Address 0x7 reads the latch AND the mask.
- R8: Writing ones to 0x6 or 0x7 clears those latch bits in edge mode and leaves the other bits unchanged.
- R9: When a clear and a new edge event hit the same latch bit in the same cycle, the bit ends up set.
- R10: The request output is high exactly when the latch AND the mask is non-zero. It follows a mask write from the next cycle.
- R11: Writes to addresses 0xA to 0xF change nothing, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_pins_i | input | 32 | Half-port inputs, half port k at bits [8k+7:8k] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Channel request |

## Verification
A wrong select field moves a whole byte of the pin-state read to another lane, and this shows in the same cycle. A latch that is set or cleared when it should not be shows at the latch or identify read one clock after the stimulus, and often in the request line as well. A wrong polarity or mode bit makes the latch contents diverge from the bench model on the first pin transition that follows. Random register traffic, with the read address changing every cycle, catches such faults within a few cycles.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_MASK_SET = 4'h0,
    A_MASK_CLR = 4'h1,
    A_EDGE_SET = 4'h2,
    A_EDGE_CLR = 4'h3,
    A_INV_SET  = 4'h4,
    A_INV_CLR  = 4'h5,
    A_LATCH    = 4'h6,
    A_REQ      = 4'h7,
    A_ASSIGN   = 4'h8,
    A_PINS     = 4'h9
  } reg_addr_e;
endpackage

// File: rtl/pint_lane_mux.sv
module pint_lane_mux #(
  parameter int NUM_HP = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic [NUM_HP*LANE_W-1:0] hp_i,
  input  logic [LANES*SEL_W-1:0]   sel_i,
  output logic [LANES*LANE_W-1:0]  pins_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel = sel_i[l*SEL_W +: SEL_W];
    always_comb begin
      pins_o[l*LANE_W +: LANE_W] = '0;
      for (int k = 0; k < NUM_HP; k++) begin
        if (sel == SEL_W'(k)) pins_o[l*LANE_W +: LANE_W] = hp_i[k*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/pint_detect.sv
module pint_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_i,
  input  logic [WIDTH-1:0] edge_i,
  input  logic [WIDTH-1:0] inv_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] pol_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [WIDTH-1:0] pol, prev_q, latch_q, evt;

  assign pol = pins_i ^ inv_i;
  assign evt = edge_i & pol & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= pol;
      latch_q <= (edge_i & ((latch_q & ~clr_i) | evt)) | (~edge_i & pol);
    end
  end

  assign latch_o = latch_q;
  assign pol_o   = pol;
  assign prev_o  = prev_q;
endmodule

// File: rtl/pint_regs.sv
module pint_regs
  import pint_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int LANES  = 4,
  parameter int NUM_HP = 4,
  parameter int SEL_W  = 2,
  localparam int ASN_W = LANES*SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  input  logic [WIDTH-1:0]  latch_i,
  input  logic [WIDTH-1:0]  pins_i,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  edge_o,
  output logic [WIDTH-1:0]  inv_o,
  output logic [ASN_W-1:0]  assign_o,
  output logic [WIDTH-1:0]  clr_o
);
  function automatic logic [ASN_W-1:0] asn_reset();
    logic [ASN_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) r[i*SEL_W +: SEL_W] = SEL_W'(i % NUM_HP);
    return r;
  endfunction

  localparam logic [ASN_W-1:0] ASN_RST = asn_reset();

  logic [WIDTH-1:0] mask_q, edge_q, inv_q;
  logic [ASN_W-1:0] asn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      edge_q <= '0;
      inv_q  <= '0;
      asn_q  <= ASN_RST;
    end else if (wr_en) begin
      case (wr_addr)
        A_MASK_SET: mask_q <= mask_q | wr_data;
        A_MASK_CLR: mask_q <= mask_q & ~wr_data;
        A_EDGE_SET: edge_q <= edge_q | wr_data;
        A_EDGE_CLR: edge_q <= edge_q & ~wr_data;
        A_INV_SET:  inv_q  <= inv_q | wr_data;
        A_INV_CLR:  inv_q  <= inv_q & ~wr_data;
        A_ASSIGN:   asn_q  <= wr_data[ASN_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en && (wr_addr == A_LATCH || wr_addr == A_REQ)) ? wr_data : '0;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_MASK_SET, A_MASK_CLR: rd_data = mask_q;
      A_EDGE_SET, A_EDGE_CLR: rd_data = edge_q;
      A_INV_SET, A_INV_CLR:   rd_data = inv_q;
      A_LATCH:                rd_data = latch_i;
      A_REQ:                  rd_data = latch_i & mask_q;
      A_ASSIGN:               rd_data[ASN_W-1:0] = asn_q;
      A_PINS:                 rd_data = pins_i;
      default: ;
    endcase
  end

  assign mask_o   = mask_q;
  assign edge_o   = edge_q;
  assign inv_o    = inv_q;
  assign assign_o = asn_q;
endmodule

// File: rtl/pint_channel.sv
module pint_channel
  import pint_pkg::*;
#(
  parameter int NUM_HP = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int WIDTH = LANES*LANE_W,
  localparam int SEL_W = (NUM_HP > 1) ? $clog2(NUM_HP) : 1,
  localparam int ASN_W = LANES*SEL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_HP*LANE_W-1:0] hp_pins_i,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     irq_o
);
  logic [WIDTH-1:0] pins_w, mask_w, edge_w, inv_w, clr_w, latch_w, pol_w, prev_w;
  logic [ASN_W-1:0] asn_w;

  pint_lane_mux #(.NUM_HP(NUM_HP), .LANES(LANES), .LANE_W(LANE_W), .SEL_W(SEL_W)) u_mux (
    .hp_i(hp_pins_i), .sel_i(asn_w), .pins_o(pins_w)
  );

  pint_detect #(.WIDTH(WIDTH)) u_det (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_w), .edge_i(edge_w), .inv_i(inv_w),
    .clr_i(clr_w), .latch_o(latch_w), .pol_o(pol_w), .prev_o(prev_w)
  );

  pint_regs #(.WIDTH(WIDTH), .LANES(LANES), .NUM_HP(NUM_HP), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .latch_i(latch_w), .pins_i(pins_w),
    .mask_o(mask_w), .edge_o(edge_w), .inv_o(inv_w), .assign_o(asn_w), .clr_o(clr_w)
  );

  assign irq_o = |(latch_w & mask_w);
endmodule

// File: rtl/pint_channel_checker.sv
module pint_channel_checker
  import pint_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WIDTH-1:0]  wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WIDTH-1:0]  rd_data,
  input logic              irq_o,
  input logic [WIDTH-1:0]  latch_q,
  input logic [WIDTH-1:0]  mask_q,
  input logic [WIDTH-1:0]  edge_q,
  input logic [WIDTH-1:0]  pol_w,
  input logic [WIDTH-1:0]  prev_q
);
  assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MASK_SET) |=> (($past(wr_data) & ~mask_q) == '0));

  assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MASK_CLR) |=> (($past(wr_data) & mask_q) == '0));

  assert_edge_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(edge_q & pol_w & ~prev_q) & ~latch_q) == '0));

  assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en && (wr_addr == A_LATCH || wr_addr == A_REQ)))
      |-> (($past(latch_q & edge_q) & ~latch_q) == '0));

  assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((~$past(edge_q) & (latch_q ^ $past(pol_w))) == '0));

  assert_irq_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_REQ) |-> (irq_o == (rd_data != '0)));
endmodule

bind pint_channel pint_channel_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .latch_q(latch_w),
  .mask_q(mask_w), .edge_q(edge_w), .pol_w(pol_w), .prev_q(prev_w)
);

// File: tb/pint_channel_bench.sv
`timescale 1ns/1ps
module pint_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hp_pins_i = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_mask, m_edge, m_inv, m_latch, m_prev;
  logic [7:0]  m_asn;

  always #10 clk = ~clk;

  pint_channel u_pint_channel (
    .clk(clk), .rst_n(rst_n), .hp_pins_i(hp_pins_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  function automatic logic [31:0] f_pins(logic [31:0] hp, logic [7:0] asn);
    logic [31:0] p;
    for (int l = 0; l < 4; l++) p[8*l +: 8] = hp[8*asn[2*l +: 2] +: 8];
    return p;
  endfunction

  function automatic logic [31:0] f_read(logic [3:0] a, logic [31:0] hp);
    case (a)
      4'h0, 4'h1: return m_mask;
      4'h2, 4'h3: return m_edge;
      4'h4, 4'h5: return m_inv;
      4'h6:       return m_latch;
      4'h7:       return m_latch & m_mask;
      4'h8:       return {24'h0, m_asn};
      4'h9:       return f_pins(hp, m_asn);
      default:    return 32'h0;
    endcase
  endfunction

  function automatic string f_tag(logic [3:0] a);
    case (a)
      4'h0, 4'h1: return "R3";
      4'h2, 4'h3, 4'h4, 4'h5: return "R4";
      4'h6, 4'h7: return "R7";
      4'h8, 4'h9: return "R2";
      default:    return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(logic w, logic [3:0] a, logic [31:0] d, logic [31:0] hp);
    logic [31:0] pol, evt, clr;
    pol = f_pins(hp, m_asn) ^ m_inv;
    evt = m_edge & pol & ~m_prev;
    clr = (w && (a == 4'h6 || a == 4'h7)) ? d : 32'h0;
    m_latch = (m_edge & ((m_latch & ~clr) | evt)) | (~m_edge & pol);
    m_prev = pol;
    if (w) begin
      case (a)
        4'h0: m_mask = m_mask | d;
        4'h1: m_mask = m_mask & ~d;
        4'h2: m_edge = m_edge | d;
        4'h3: m_edge = m_edge & ~d;
        4'h4: m_inv  = m_inv | d;
        4'h5: m_inv  = m_inv & ~d;
        4'h8: m_asn  = d[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic cycle(logic w, logic [3:0] a, logic [31:0] d, logic [3:0] ra, logic [31:0] hp);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; rd_addr = ra; hp_pins_i = hp;
    #1;
    chk(f_tag(ra), rd_data, f_read(ra, hp));
    chk("R10", {31'h0, irq_o}, {31'h0, |(m_latch & m_mask)});
    model_step(w, a, d, hp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] hp;
    void'($urandom(32'd4242));
    m_mask = '0; m_edge = '0; m_inv = '0; m_latch = '0; m_prev = '0; m_asn = 8'hE4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cycle(0, 0, 0, 4'h8, 0);
    chk("R1", rd_data, 32'hE4);
    cycle(0, 0, 0, 4'h6, 0);
    chk("R1", rd_data, 32'h0);
    chk("R1", {31'h0, irq_o}, 32'h0);

    // R2 lane assignment reversed
    cycle(1, 4'h8, 32'h1B, 4'h9, 32'h44332211);
    cycle(0, 0, 0, 4'h9, 32'h44332211);
    chk("R2", rd_data, 32'h11223344);
    cycle(1, 4'h8, 32'hE4, 4'h9, 0);

    // R5 edge latch and hold, R8 clear, R9 event beats clear
    cycle(1, 4'h2, 32'h1, 4'h6, 0);
    cycle(0, 0, 0, 4'h6, 32'h1);
    cycle(0, 0, 0, 4'h6, 32'h0);
    chk("R5", rd_data & 32'h1, 32'h1);
    cycle(0, 0, 0, 4'h6, 32'h0);
    chk("R5", rd_data & 32'h1, 32'h1);
    cycle(1, 4'h6, 32'h1, 4'h6, 0);
    cycle(0, 0, 0, 4'h6, 0);
    chk("R8", rd_data & 32'h1, 32'h0);
    cycle(1, 4'h6, 32'h1, 4'h6, 32'h1);
    cycle(0, 0, 0, 4'h6, 32'h1);
    chk("R9", rd_data & 32'h1, 32'h1);

    // R10 mask makes request
    cycle(1, 4'h0, 32'h1, 4'h7, 32'h1);
    cycle(0, 0, 0, 4'h7, 32'h1);
    chk("R10", {31'h0, irq_o}, 32'h1);
    cycle(1, 4'h1, 32'h1, 4'h7, 32'h1);
    cycle(0, 0, 0, 4'h7, 32'h1);
    chk("R10", {31'h0, irq_o}, 32'h0);

    // R6 level bit ignores clear
    cycle(0, 0, 0, 4'h6, 32'h3);
    cycle(1, 4'h6, 32'h2, 4'h6, 32'h3);
    cycle(0, 0, 0, 4'h6, 32'h3);
    chk("R6", rd_data & 32'h2, 32'h2);
    cycle(0, 0, 0, 4'h6, 32'h1);
    cycle(0, 0, 0, 4'h6, 32'h1);
    chk("R6", rd_data & 32'h2, 32'h0);

    // R11 unused address
    cycle(1, 4'hC, 32'hFFFFFFFF, 4'hC, 32'h1);
    chk("R11", rd_data, 32'h0);
    cycle(0, 0, 0, 4'h0, 32'h1);
    chk("R11", rd_data, 32'h0);

    // random traffic against the model
    hp = 32'h0;
    for (int i = 0; i < 600; i++) begin
      logic w;
      logic [3:0] a;
      logic [31:0] d;
      hp = hp ^ ($urandom & $urandom);
      w = ($urandom % 2) == 0;
      a = 4'($urandom % 16);
      d = $urandom & $urandom;
      cycle(w, a, d, 4'($urandom % 16), hp);
    end

    finish_run();
  end
endmodule